// File: doc/BRIEF.md
# RAID Parity Command Checker

This block screens a RAID parity command before any engine acts on it. The command arrives as 64-bit words on a valid/ready stream. The first word is a control word. If the P pipe is enabled, one output descriptor for P follows. If the Q pipe is enabled, one output descriptor for Q follows, after the P descriptor. Last come as many input descriptors as the control word declares. Each word is decoded as it is accepted and checked against the rules for its own fields and against the rules that tie it to the control word.

The block latches the first broken rule as a 4-bit code. It keeps accepting the rest of the command's words even after a rule is broken. One cycle after the last word is accepted, it raises a single-cycle result pulse that carries either a pass or the latched code. Two rules can only be judged once all inputs are in: an enabled P pipe must have at least one contributing input, and so must an enabled Q pipe. These are evaluated at the end of the command.

Top module: `raidcmd_checker`

## Requirements
- R1: A word is taken when `in_valid` and `in_ready` are both high. `in_ready` is high in every cycle except the result cycle. A command is the control word, then a P output descriptor if P is on, then a Q output descriptor if Q is on, then exactly the declared number of input descriptors, even when that number is out of range.
- R2: `res_valid` is high for exactly one cycle, the cycle after the last word of a command is taken. In that cycle `res_ok` is 1 exactly when `res_code` is 0. Outside that cycle all three result outputs are 0.
- R3: Control word bits [31:30] and [63:39] are reserved. Any of them set gives code 1.
- R4: The control word byte size is in bits [23:0]. If its bits [2:0] are nonzero, the code is 2. The input count is in bits [29:24]. A count of 0 or above 32 gives code 3.
- R5: P output is enabled by bit 32 and Q output by bit 33. If neither is set, the code is 4.
- R6: P compare (bit 36) set while P output is off or P cross-XOR (bit 34) is set gives code 5. Q compare (bit 37) set while Q output is off or Q cross-XOR (bit 35) is set also gives code 5.
- R7: Either cross-XOR bit set without both outputs enabled gives code 6. Bit 38 (notify kind) carries no rule.
- R8: In an output descriptor, bits [47:40] and [63:50] are reserved, and any of them set gives code 7. No-allocate (bit 48) or full-write (bit 49) set while that descriptor's pipe is in compare mode gives code 8.
- R9: In an input descriptor, bits [63:51] are reserved, and any of them set gives code 9. Address bits [2:0] nonzero give code 10.
- R10: An input with P-enable (bit 48) set while P output is off, or with Q-enable (bit 49) set while Q output is off, gives code 11.
- R11: The Q multiplier is in input bits [47:40]. A nonzero multiplier with Q-enable clear, or a zero multiplier with Q-enable set, gives code 12.
- R12: At the end of a command with no earlier error, P on with no P-enabled input gives code 13. Failing that, Q on with no Q-enabled input gives code 14.
- R13: The code of the earliest failing word is reported. Within one word, the lowest applicable code wins. Later words neither overwrite nor clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word present |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 64 | Command word |
| res_valid | output | 1 | One-cycle result pulse |
| res_ok | output | 1 | Command passed every rule |
| res_code | output | 4 | First broken rule, 0 for pass |

## Verification
The assertions assume that `in_word` is fully known whenever `in_valid` is high and that reset is held through at least one rising edge. They also assume that a producer never expects a result before it has sent the declared number of words. The stimulus changes inputs only at falling edges and always sends exactly the word count implied by the control word. It sometimes inserts idle gaps, and once it offers a word during the result cycle to check that the word is refused.

// File: rtl/raidcmd_pkg.sv
package raidcmd_pkg;
   localparam int WORD_W  = 64;
   localparam int CNT_W   = 6;
   localparam int CODE_W  = 4;
   localparam int ALIGN_W = 3;
   localparam int QMUL_W  = 8;

   // control word bit positions
   localparam int C_CNT_LO  = 24;
   localparam int C_P_ON    = 32;
   localparam int C_Q_ON    = 33;
   localparam int C_P_MIX   = 34;
   localparam int C_Q_MIX   = 35;
   localparam int C_P_CMP   = 36;
   localparam int C_Q_CMP   = 37;
   localparam int C_NOTIFY  = 38;

   // output descriptor bit positions
   localparam int O_NOALLOC = 48;
   localparam int O_FULLWR  = 49;

   // input descriptor bit positions
   localparam int I_QMUL_LO = 40;
   localparam int I_PEN     = 48;
   localparam int I_QEN     = 49;
   localparam int I_NOALLOC = 50;

   typedef enum logic [CODE_W-1:0] {
      E_NONE       = 4'd0,
      E_CTL_RSVD   = 4'd1,
      E_SIZE_ALIGN = 4'd2,
      E_COUNT      = 4'd3,
      E_NO_OUTPUT  = 4'd4,
      E_CMP_CONF   = 4'd5,
      E_MIX_ONE    = 4'd6,
      E_OUT_RSVD   = 4'd7,
      E_OUT_CMPFLG = 4'd8,
      E_IN_RSVD    = 4'd9,
      E_IN_ALIGN   = 4'd10,
      E_IN_EN_OFF  = 4'd11,
      E_QMUL       = 4'd12,
      E_P_UNUSED   = 4'd13,
      E_Q_UNUSED   = 4'd14
   } err_e;

   typedef enum logic [2:0] {
      PH_CTL, PH_OUTP, PH_OUTQ, PH_IN, PH_DONE
   } phase_e;

   typedef struct packed {
      logic             p_on;
      logic             q_on;
      logic             p_mix;
      logic             q_mix;
      logic             p_cmp;
      logic             q_cmp;
      logic [CNT_W-1:0] count;
   } ctl_t;

   function automatic ctl_t ctl_decode(input logic [WORD_W-1:0] w);
      ctl_t c;
      c.p_on  = w[C_P_ON];
      c.q_on  = w[C_Q_ON];
      c.p_mix = w[C_P_MIX];
      c.q_mix = w[C_Q_MIX];
      c.p_cmp = w[C_P_CMP];
      c.q_cmp = w[C_Q_CMP];
      c.count = w[C_CNT_LO +: CNT_W];
      return c;
   endfunction
endpackage

// File: rtl/raidcmd_ctl_rules.sv
module raidcmd_ctl_rules
   import raidcmd_pkg::*;
#(
   parameter int MAX_INPUTS = 32
) (
   input  logic [WORD_W-1:0] word,
   output err_e              code
);
   localparam int CNT_TOP = (1 << CNT_W) - 1;

   ctl_t c;
   logic rsvd_set;
   logic over_lim;
   logic unused_ctl;

   assign c          = ctl_decode(word);
   assign rsvd_set   = (|word[31:30]) | (|word[WORD_W-1:C_NOTIFY+1]);
   assign unused_ctl = ^{word[23:ALIGN_W], word[C_NOTIFY]};

   generate
      if (MAX_INPUTS >= CNT_TOP) begin : g_full_range
         assign over_lim = 1'b0;
      end else begin : g_limited
         assign over_lim = c.count > CNT_W'(MAX_INPUTS);
      end
   endgenerate

   always_comb begin
      if (rsvd_set)
         code = E_CTL_RSVD;
      else if (|word[ALIGN_W-1:0])
         code = E_SIZE_ALIGN;
      else if (c.count == '0 || over_lim)
         code = E_COUNT;
      else if (!c.p_on && !c.q_on)
         code = E_NO_OUTPUT;
      else if ((c.p_cmp && (!c.p_on || c.p_mix)) || (c.q_cmp && (!c.q_on || c.q_mix)))
         code = E_CMP_CONF;
      else if ((c.p_mix || c.q_mix) && !(c.p_on && c.q_on))
         code = E_MIX_ONE;
      else
         code = E_NONE;
   end

   always_comb begin
      // R4
      if (c.count == '0) count_zero_chk: assert (code != E_NONE);
      // R5
      if (!c.p_on && !c.q_on) no_output_chk: assert (code != E_NONE);
   end
endmodule

// File: rtl/raidcmd_desc_rules.sv
module raidcmd_desc_rules
   import raidcmd_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   input  logic              is_out,
   input  logic              pipe_cmp,
   input  logic              p_on,
   input  logic              q_on,
   output err_e              code
);
   logic [QMUL_W-1:0] qmul;
   logic out_rsvd, out_flag, in_rsvd, in_misalign, in_en_off, in_qmul_bad;
   logic unused_desc;

   assign qmul        = word[I_QMUL_LO +: QMUL_W];
   assign out_rsvd    = (|word[47:40]) | (|word[WORD_W-1:O_FULLWR+1]);
   assign out_flag    = pipe_cmp && (word[O_NOALLOC] || word[O_FULLWR]);
   assign in_rsvd     = |word[WORD_W-1:I_NOALLOC+1];
   assign in_misalign = |word[ALIGN_W-1:0];
   assign in_en_off   = (word[I_PEN] && !p_on) || (word[I_QEN] && !q_on);
   assign in_qmul_bad = word[I_QEN] ? (qmul == '0) : (qmul != '0);
   assign unused_desc = ^{word[39:ALIGN_W], word[I_NOALLOC]};

   always_comb begin
      if (is_out) begin
         if (out_rsvd)      code = E_OUT_RSVD;
         else if (out_flag) code = E_OUT_CMPFLG;
         else               code = E_NONE;
      end else begin
         if (in_rsvd)          code = E_IN_RSVD;
         else if (in_misalign) code = E_IN_ALIGN;
         else if (in_en_off)   code = E_IN_EN_OFF;
         else if (in_qmul_bad) code = E_QMUL;
         else                  code = E_NONE;
      end
   end

   always_comb begin
      // R9
      if (!is_out && (|word[ALIGN_W-1:0])) in_align_chk: assert (code != E_NONE);
      // R11
      if (!is_out && word[I_QEN] && qmul == '0) qmul_zero_chk: assert (code != E_NONE);
   end
endmodule

// File: rtl/raidcmd_seq.sv
module raidcmd_seq
   import raidcmd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             p_on,
   input  logic             q_on,
   input  logic [CNT_W-1:0] count,
   output phase_e           phase
);
   phase_e           phase_q, phase_d;
   logic [CNT_W-1:0] left_q, left_d;

   always_comb begin
      phase_d = phase_q;
      left_d  = left_q;
      case (phase_q)
         PH_CTL: if (fire) begin
            left_d = count;
            if (p_on)              phase_d = PH_OUTP;
            else if (q_on)         phase_d = PH_OUTQ;
            else if (count != '0)  phase_d = PH_IN;
            else                   phase_d = PH_DONE;
         end
         PH_OUTP: if (fire) begin
            if (q_on)              phase_d = PH_OUTQ;
            else if (left_q != '0) phase_d = PH_IN;
            else                   phase_d = PH_DONE;
         end
         PH_OUTQ: if (fire) begin
            if (left_q != '0)      phase_d = PH_IN;
            else                   phase_d = PH_DONE;
         end
         PH_IN: if (fire) begin
            left_d = left_q - 1'b1;
            if (left_q == CNT_W'(1)) phase_d = PH_DONE;
         end
         default: phase_d = PH_CTL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_CTL;
         left_q  <= '0;
      end else begin
         phase_q <= phase_d;
         left_q  <= left_d;
      end
   end

   assign phase = phase_q;

   // R1
   in_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_IN |-> left_q != '0);
   // R2
   done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_DONE |=> phase_q == PH_CTL);
endmodule

// File: rtl/raidcmd_checker.sv
module raidcmd_checker
   import raidcmd_pkg::*;
#(
   parameter int MAX_INPUTS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   output logic              res_valid,
   output logic              res_ok,
   output logic [CODE_W-1:0] res_code
);
   generate
      if (MAX_INPUTS < 1 || MAX_INPUTS >= (1 << CNT_W) + 1) begin : g_bad_limit
         $error("MAX_INPUTS must fit the input count field");
      end
   endgenerate

   phase_e phase;
   ctl_t   live, ctl_q, eff;
   err_e   ctl_code, desc_code, err_q, fin;
   logic   fire, seen_p, seen_q;
   logic   unused_top;

   assign in_ready   = (phase != PH_DONE);
   assign fire       = in_valid && in_ready;
   assign live       = ctl_decode(in_word);
   assign eff        = (phase == PH_CTL) ? live : ctl_q;
   assign unused_top = ^{eff.p_mix, eff.q_mix, eff.p_cmp, eff.q_cmp};

   raidcmd_ctl_rules #(.MAX_INPUTS(MAX_INPUTS)) u_ctl (
      .word (in_word),
      .code (ctl_code)
   );

   raidcmd_desc_rules u_desc (
      .word     (in_word),
      .is_out   (phase == PH_OUTP || phase == PH_OUTQ),
      .pipe_cmp ((phase == PH_OUTP) ? ctl_q.p_cmp : ctl_q.q_cmp),
      .p_on     (ctl_q.p_on),
      .q_on     (ctl_q.q_on),
      .code     (desc_code)
   );

   raidcmd_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .p_on  (eff.p_on),
      .q_on  (eff.q_on),
      .count (eff.count),
      .phase (phase)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         err_q  <= E_NONE;
         seen_p <= 1'b0;
         seen_q <= 1'b0;
      end else if (fire) begin
         if (phase == PH_CTL) begin
            ctl_q  <= live;
            err_q  <= ctl_code;
            seen_p <= 1'b0;
            seen_q <= 1'b0;
         end else begin
            if (err_q == E_NONE) err_q <= desc_code;
            if (phase == PH_IN) begin
               seen_p <= seen_p | in_word[I_PEN];
               seen_q <= seen_q | in_word[I_QEN];
            end
         end
      end
   end

   always_comb begin
      if (err_q != E_NONE)           fin = err_q;
      else if (ctl_q.p_on && !seen_p) fin = E_P_UNUSED;
      else if (ctl_q.q_on && !seen_q) fin = E_Q_UNUSED;
      else                            fin = E_NONE;
   end

   assign res_valid = (phase == PH_DONE);
   assign res_code  = res_valid ? fin : E_NONE;
   assign res_ok    = res_valid && (fin == E_NONE);

   // R2
   result_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(fire));
   // R2
   res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   // R13
   first_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q != E_NONE && !(fire && phase == PH_CTL)) |=> err_q == $past(err_q));
endmodule

// File: tb/raidcmd_checker_bench.sv
module raidcmd_checker_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_word = '0;
   logic        res_valid;
   logic        res_ok;
   logic [3:0]  res_code;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   raidcmd_checker u_raidcmd_checker (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .res_valid(res_valid), .res_ok(res_ok), .res_code(res_code)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_ctl(input int size, input int cnt, input bit p, input bit q,
                                          input bit pm, input bit qm, input bit pc, input bit qc);
      logic [63:0] w = '0;
      w[23:0] = size[23:0]; w[29:24] = cnt[5:0];
      w[32] = p; w[33] = q; w[34] = pm; w[35] = qm; w[36] = pc; w[37] = qc;
      return w;
   endfunction

   function automatic logic [63:0] mk_out(input logic [39:0] a, input bit na, input bit fw);
      logic [63:0] w = '0;
      w[39:0] = a; w[48] = na; w[49] = fw;
      return w;
   endfunction

   function automatic logic [63:0] mk_in(input logic [39:0] a, input int qm, input bit pe, input bit qe);
      logic [63:0] w = '0;
      w[39:0] = a; w[47:40] = qm[7:0]; w[48] = pe; w[49] = qe;
      return w;
   endfunction

   // Behavioural model of the rules, first failing word wins
   function automatic int model_code(input logic [63:0] ws[$]);
      logic [63:0] c = ws[0];
      int code = 0, idx = 1, cnt = int'(c[29:24]);
      bit p = c[32], q = c[33], pm = c[34], qm = c[35], pc = c[36], qc = c[37];
      bit sp = 0, sq = 0;
      if (c[31:30] != 0 || c[63:39] != 0) code = 1;
      else if (c[2:0] != 0) code = 2;
      else if (cnt == 0 || cnt > 32) code = 3;
      else if (!p && !q) code = 4;
      else if ((pc && (!p || pm)) || (qc && (!q || qm))) code = 5;
      else if ((pm || qm) && !(p && q)) code = 6;
      for (int k = 0; k < 2; k++) begin
         bit on = (k == 0) ? p : q;
         bit cm = (k == 0) ? pc : qc;
         if (on) begin
            logic [63:0] w = ws[idx];
            int e = 0;
            if (w[47:40] != 0 || w[63:50] != 0) e = 7;
            else if (cm && (w[48] || w[49])) e = 8;
            if (code == 0) code = e;
            idx++;
         end
      end
      for (int n = 0; n < cnt; n++) begin
         logic [63:0] w = ws[idx];
         int e = 0;
         if (w[63:51] != 0) e = 9;
         else if (w[2:0] != 0) e = 10;
         else if ((w[48] && !p) || (w[49] && !q)) e = 11;
         else if (w[49] ? (w[47:40] == 0) : (w[47:40] != 0)) e = 12;
         if (code == 0) code = e;
         sp |= w[48]; sq |= w[49];
         idx++;
      end
      if (code == 0 && p && !sp) code = 13;
      else if (code == 0 && q && !sq) code = 14;
      return code;
   endfunction

   task automatic run_cmd(input logic [63:0] ws[$], input int gap, input string req, input bit poke);
      int exp = model_code(ws);
      for (int i = 0; i < ws.size(); i++) begin
         if (i > 0) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               in_valid = 1'b0;
               chk(req, "gap in_ready", in_ready, 1);
               chk(req, "gap res_valid", res_valid, 0);
               @(posedge clk);
            end
         end
         @(negedge clk);
         chk(req, "in_ready", in_ready, 1);
         chk(req, "res_valid early", res_valid, 0);
         in_valid = 1'b1;
         in_word  = ws[i];
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = poke;
      in_word  = mk_ctl(8, 1, 1, 0, 0, 0, 0, 0);
      chk(req, "res_valid", res_valid, 1);
      chk(req, "res_code", res_code, exp);
      chk(req, "res_ok", res_ok, (exp == 0));
      chk("R1", "in_ready in result cycle", in_ready, 0);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2", "res_valid after pulse", res_valid, 0);
      chk("R2", "res_code after pulse", res_code, 0);
      chk("R1", "in_ready after pulse", in_ready, 1);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [63:0] ws[$];
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "reset in_ready", in_ready, 1);
      chk("R2", "reset res_valid", res_valid, 0);
      chk("R2", "reset res_ok", res_ok, 0);
      rst_n = 1'b1;

      // R1 R2: passing command with both pipes
      ws = '{mk_ctl(64, 3, 1, 1, 0, 0, 0, 0), mk_out(40'h100, 0, 0), mk_out(40'h200, 1, 1),
             mk_in(40'h1000, 2, 1, 1), mk_in(40'h2008, 5, 1, 1), mk_in(40'h3010, 0, 1, 0)};
      run_cmd(ws, 0, "R2", 0);
      // R1: Q only with idle gaps
      ws = '{mk_ctl(16, 2, 0, 1, 0, 0, 0, 0), mk_out(40'h300, 0, 0),
             mk_in(40'h40, 1, 0, 1), mk_in(40'h48, 0, 0, 0)};
      run_cmd(ws, 2, "R1", 0);
      // R3: reserved control bit
      ws = '{mk_ctl(8, 1, 1, 0, 0, 0, 0, 0) | (64'd1 << 50), mk_out(40'h0, 0, 0), mk_in(40'h8, 0, 1, 0)};
      run_cmd(ws, 0, "R3", 0);
      ws = '{mk_ctl(8, 1, 1, 0, 0, 0, 0, 0) | (64'd1 << 30), mk_out(40'h0, 0, 0), mk_in(40'h8, 0, 1, 0)};
      run_cmd(ws, 0, "R3", 0);
      // R4: size misaligned, count zero, count above limit
      ws = '{mk_ctl(12, 1, 1, 0, 0, 0, 0, 0), mk_out(40'h0, 0, 0), mk_in(40'h8, 0, 1, 0)};
      run_cmd(ws, 0, "R4", 0);
      ws = '{mk_ctl(8, 0, 1, 0, 0, 0, 0, 0), mk_out(40'h0, 0, 0)};
      run_cmd(ws, 0, "R4", 0);
      ws = '{mk_ctl(8, 33, 1, 0, 0, 0, 0, 0), mk_out(40'h0, 0, 0)};
      for (int i = 0; i < 33; i++) ws.push_back(mk_in(40'(i * 8), 0, 1, 0));
      run_cmd(ws, 0, "R4", 0);
      // R1 R2: exactly 32 inputs pass
      ws = '{mk_ctl(8, 32, 1, 0, 0, 0, 0, 0), mk_out(40'h0, 0, 0)};
      for (int i = 0; i < 32; i++) ws.push_back(mk_in(40'(i * 8), 0, 1, 0));
      run_cmd(ws, 0, "R1", 0);
      // R5: no output enabled
      ws = '{mk_ctl(8, 1, 0, 0, 0, 0, 0, 0), mk_in(40'h8, 0, 0, 0)};
      run_cmd(ws, 0, "R5", 0);
      // R6: compare with pipe off, compare with cross-XOR
      ws = '{mk_ctl(8, 1, 0, 1, 0, 0, 1, 0), mk_out(40'h0, 0, 0), mk_in(40'h8, 3, 0, 1)};
      run_cmd(ws, 0, "R6", 0);
      ws = '{mk_ctl(8, 1, 1, 1, 0, 1, 0, 1), mk_out(40'h0, 0, 0), mk_out(40'h0, 0, 0), mk_in(40'h8, 3, 1, 1)};
      run_cmd(ws, 0, "R6", 0);
      // R7: cross-XOR with one output only; notify bit is free
      ws = '{mk_ctl(8, 1, 1, 0, 1, 0, 0, 0), mk_out(40'h0, 0, 0), mk_in(40'h8, 0, 1, 0)};
      run_cmd(ws, 0, "R7", 0);
      ws = '{mk_ctl(8, 1, 1, 1, 1, 1, 0, 0) | (64'd1 << 38), mk_out(40'h0, 0, 0), mk_out(40'h0, 0, 0),
             mk_in(40'h8, 9, 1, 1)};
      run_cmd(ws, 0, "R7", 0);
      // R8: output reserved, flags while comparing, compare pass
      ws = '{mk_ctl(8, 1, 1, 0, 0, 0, 0, 0), mk_out(40'h0, 0, 0) | (64'd1 << 44), mk_in(40'h8, 0, 1, 0)};
      run_cmd(ws, 0, "R8", 0);
      ws = '{mk_ctl(8, 1, 1, 1, 0, 0, 0, 1), mk_out(40'h0, 1, 1), mk_out(40'h0, 0, 1), mk_in(40'h8, 4, 1, 1)};
      run_cmd(ws, 0, "R8", 0);
      ws = '{mk_ctl(8, 1, 1, 1, 0, 0, 1, 1), mk_out(40'h0, 0, 0), mk_out(40'h0, 0, 0), mk_in(40'h8, 4, 1, 1)};
      run_cmd(ws, 0, "R8", 0);
      // R9: input reserved, misaligned
      ws = '{mk_ctl(8, 1, 1, 0, 0, 0, 0, 0), mk_out(40'h0, 0, 0), mk_in(40'h8, 0, 1, 0) | (64'd1 << 60)};
      run_cmd(ws, 0, "R9", 0);
      ws = '{mk_ctl(8, 1, 1, 0, 0, 0, 0, 0), mk_out(40'h0, 0, 0), mk_in(40'h4, 0, 1, 0)};
      run_cmd(ws, 0, "R9", 0);
      // R10: enable for a pipe that is off
      ws = '{mk_ctl(8, 2, 0, 1, 0, 0, 0, 0), mk_out(40'h0, 0, 0), mk_in(40'h8, 1, 0, 1), mk_in(40'h10, 0, 1, 0)};
      run_cmd(ws, 0, "R10", 0);
      // R11: bad multipliers
      ws = '{mk_ctl(8, 1, 0, 1, 0, 0, 0, 0), mk_out(40'h0, 0, 0), mk_in(40'h8, 0, 0, 1)};
      run_cmd(ws, 0, "R11", 0);
      ws = '{mk_ctl(8, 2, 1, 0, 0, 0, 0, 0), mk_out(40'h0, 0, 0), mk_in(40'h8, 0, 1, 0), mk_in(40'h10, 7, 1, 0)};
      run_cmd(ws, 0, "R11", 0);
      // R12: pipes with no contributing input
      ws = '{mk_ctl(8, 1, 1, 1, 0, 0, 0, 0), mk_out(40'h0, 0, 0), mk_out(40'h0, 0, 0), mk_in(40'h8, 2, 0, 1)};
      run_cmd(ws, 0, "R12", 0);
      ws = '{mk_ctl(8, 1, 1, 1, 0, 0, 0, 0), mk_out(40'h0, 0, 0), mk_out(40'h0, 0, 0), mk_in(40'h8, 0, 1, 0)};
      run_cmd(ws, 0, "R12", 0);
      // R13: earliest word wins, lowest code within a word; poke during result
      ws = '{mk_ctl(8, 2, 1, 0, 0, 0, 0, 0), mk_out(40'h0, 0, 0), mk_in(40'h9, 0, 1, 0),
             mk_in(40'h10, 0, 1, 0) | (64'd1 << 55)};
      run_cmd(ws, 1, "R13", 1);
      ws = '{mk_ctl(20, 1, 1, 0, 0, 0, 0, 0), mk_out(40'h0, 0, 0) | (64'd1 << 41), mk_in(40'h3, 0, 1, 0)};
      run_cmd(ws, 0, "R13", 0);
      ws = '{mk_ctl(8, 1, 1, 0, 0, 0, 0, 0), mk_out(40'h0, 0, 0), mk_in(40'h5, 0, 1, 1) | (64'd1 << 51)};
      run_cmd(ws, 0, "R13", 0);
      // R1: the word offered during the previous result cycle was refused
      ws = '{mk_ctl(8, 1, 0, 1, 0, 0, 0, 0), mk_out(40'h0, 0, 0), mk_in(40'h8, 1, 0, 1)};
      run_cmd(ws, 0, "R1", 0);

      finish_run();
   end
endmodule